// File: doc/BRIEF.md
# Masked Element-Serial Vector Unit

This block runs one vector instruction at a time over a local file of vector registers. A command names an operation, a destination register and two source registers. Once accepted, the unit sends one element per clock into the functional unit that the operation selects. It starts at element zero and stops at the current vector length. Results are written back in element order. The functional units are fixed-latency pipelines, so element i is written exactly i cycles after element zero. No hazard logic is needed, because elements of one vector never depend on each other.

Two control registers shape every vector instruction. The length register limits how many elements are processed. The predicate register chooses which of those elements may be written. Compare instructions fill the predicate register from a zero test on a source vector. A configuration command can restore the predicate to all ones. Separate element-wide load and read ports let the surrounding logic fill and inspect the registers.

Top module: `vec_mask_unit`

## Requirements
- R1: After reset, vlen_o equals NELEM, mask_o is all ones, busy and done are low and cmd_ready is high.
- R2: Operation code 5 sets the length register to cmd_len, clamped to NELEM. The change is visible in the cycle after acceptance, and done pulses in that same cycle.
- R3: Operation code 0 writes dst[i] = (src1[i] + src2[i]) mod 2^EW through a 4-cycle adder pipeline.
- R4: Operation code 1 writes dst[i] = src1[i] logically shifted right by one, with a latency of 1.
- R5: Operation code 2 writes the low EW bits of src1[i] * src2[i] (unsigned) through a 6-cycle multiplier pipeline.
- R6: Operation code 3 sets predicate bit i to (src1[i] == 0), and code 4 sets it to (src1[i] != 0). Both run for every i below the length, ignore the existing predicate and have a latency of 1. Bits at or above the length keep their value.
- R7: An arithmetic operation leaves unchanged every destination element whose predicate bit is 0, and every element whose index is at or above the length.
- R8: Operation code 6 sets every predicate bit to 1, and done pulses in the cycle after acceptance.
- R9: For a vector operation with latency L and length n > 0, done is a one-cycle pulse L+n-1 clock edges after the accepting edge. busy is high from the accepting edge until that pulse and is low while done is high.
- R10: A vector operation issued while the length is 0 writes nothing, never raises busy, and pulses done in the cycle after acceptance.
- R11: cmd_ready is low while busy. A command presented while busy is dropped and does not change the length, the predicate or any register.
- R12: ld_en writes ld_data into element ld_idx of register ld_reg at the clock edge. rd_data shows element rd_idx of register rd_reg combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle; a command is taken this cycle |
| cmd_op | input | 3 | Operation code (0 add, 1 shift, 2 multiply, 3 zero test, 4 nonzero test, 5 set length, 6 predicate to ones, 7 no-op) |
| cmd_dst | input | RW | Destination register |
| cmd_src1 | input | RW | First source register |
| cmd_src2 | input | RW | Second source register |
| cmd_len | input | LW | New length for operation code 5 |
| busy | output | 1 | A vector instruction is in flight |
| done | output | 1 | One-cycle completion pulse |
| ld_en | input | 1 | Element load strobe |
| ld_reg | input | RW | Load register select |
| ld_idx | input | IW | Load element index |
| ld_data | input | EW | Load data |
| rd_reg | input | RW | Read register select |
| rd_idx | input | IW | Read element index |
| rd_data | output | EW | Read data |
| vlen_o | output | LW | Current length register |
| mask_o | output | NELEM | Current predicate register |

## Verification
Each command's completion is due at a fixed edge count after the edge that accepts it. That count is 0 for length and predicate configuration and for a zero length. For a vector operation it is the unit latency plus the length minus one: 4 for add, 6 for multiply, 1 for shift and compare. The bench counts falling-edge samples from acceptance until done and compares the count with this figure. It also confirms that busy stayed high throughout and that done is low again one cycle later. Only after the pulse does it read back every element, the length and the predicate, against a model updated from the requirements. That way the state checks never race the pipelines.

// File: rtl/vmu_pkg.sv
package vmu_pkg;

    typedef enum logic [2:0] {
        OP_ADD     = 3'd0,
        OP_SHR     = 3'd1,
        OP_MUL     = 3'd2,
        OP_CMPEQZ  = 3'd3,
        OP_CMPNEZ  = 3'd4,
        OP_SETLEN  = 3'd5,
        OP_MASKALL = 3'd6,
        OP_NOP     = 3'd7
    } vop_e;

    localparam int ONE_LAT = 1;

    function automatic logic op_arith(vop_e o);
        return (o == OP_ADD) || (o == OP_SHR) || (o == OP_MUL);
    endfunction

    function automatic logic op_cmp(vop_e o);
        return (o == OP_CMPEQZ) || (o == OP_CMPNEZ);
    endfunction

endpackage

// File: rtl/vmu_pipe.sv
module vmu_pipe #(
    parameter int LAT = 4,
    parameter int W   = 64,
    parameter int IW  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [IW-1:0] in_idx,
    input  logic [W-1:0]  in_data,
    output logic          out_vld,
    output logic [IW-1:0] out_idx,
    output logic [W-1:0]  out_data
);

    generate
        if (LAT <= 1) begin : g_pass
            assign out_vld  = in_vld;
            assign out_idx  = in_idx;
            assign out_data = in_data;
        end else begin : g_stage
            localparam int NS = LAT - 1;
            logic [NS-1:0] vld_d, vld_q;
            logic [IW-1:0] idx_d [NS];
            logic [IW-1:0] idx_q [NS];
            logic [W-1:0]  dat_d [NS];
            logic [W-1:0]  dat_q [NS];

            always_comb begin
                vld_d[0] = in_vld;
                idx_d[0] = in_idx;
                dat_d[0] = in_data;
                for (int s = 1; s < NS; s++) begin
                    vld_d[s] = vld_q[s-1];
                    idx_d[s] = idx_q[s-1];
                    dat_d[s] = dat_q[s-1];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) vld_q <= '0;
                else        vld_q <= vld_d;
            end

            always_ff @(posedge clk) begin
                idx_q <= idx_d;
                dat_q <= dat_d;
            end

            assign out_vld  = vld_q[NS-1];
            assign out_idx  = idx_q[NS-1];
            assign out_data = dat_q[NS-1];
        end
    endgenerate

endmodule

// File: rtl/vmu_regfile.sv
module vmu_regfile #(
    parameter  int NREG  = 8,
    parameter  int NELEM = 64,
    parameter  int EW    = 64,
    localparam int RW    = (NREG  > 1) ? $clog2(NREG)  : 1,
    localparam int IW    = (NELEM > 1) ? $clog2(NELEM) : 1,
    localparam int DEPTH = 2 ** (RW + IW)
) (
    input  logic          clk,
    input  logic [RW-1:0] ra_reg,
    input  logic [IW-1:0] ra_idx,
    output logic [EW-1:0] ra_data,
    input  logic [RW-1:0] rb_reg,
    input  logic [IW-1:0] rb_idx,
    output logic [EW-1:0] rb_data,
    input  logic [RW-1:0] rc_reg,
    input  logic [IW-1:0] rc_idx,
    output logic [EW-1:0] rc_data,
    input  logic          ld_en,
    input  logic [RW-1:0] ld_reg,
    input  logic [IW-1:0] ld_idx,
    input  logic [EW-1:0] ld_data,
    input  logic          wb_en,
    input  logic [RW-1:0] wb_reg,
    input  logic [IW-1:0] wb_idx,
    input  logic [EW-1:0] wb_data
);

    logic [EW-1:0] mem_q [DEPTH];

    assign ra_data = mem_q[{ra_reg, ra_idx}];
    assign rb_data = mem_q[{rb_reg, rb_idx}];
    assign rc_data = mem_q[{rc_reg, rc_idx}];

    // writeback is issued last so it wins a same-address collision
    always_ff @(posedge clk) begin
        if (ld_en) mem_q[{ld_reg, ld_idx}] <= ld_data;
        if (wb_en) mem_q[{wb_reg, wb_idx}] <= wb_data;
    end

endmodule

// File: rtl/vec_mask_unit.sv
module vec_mask_unit
    import vmu_pkg::*;
#(
    parameter  int NREG    = 8,
    parameter  int NELEM   = 64,
    parameter  int EW      = 64,
    parameter  int ADD_LAT = 4,
    parameter  int MUL_LAT = 6,
    localparam int RW      = (NREG  > 1) ? $clog2(NREG)  : 1,
    localparam int IW      = (NELEM > 1) ? $clog2(NELEM) : 1,
    localparam int LW      = $clog2(NELEM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic [RW-1:0]    cmd_dst,
    input  logic [RW-1:0]    cmd_src1,
    input  logic [RW-1:0]    cmd_src2,
    input  logic [LW-1:0]    cmd_len,
    output logic             busy,
    output logic             done,
    input  logic             ld_en,
    input  logic [RW-1:0]    ld_reg,
    input  logic [IW-1:0]    ld_idx,
    input  logic [EW-1:0]    ld_data,
    input  logic [RW-1:0]    rd_reg,
    input  logic [IW-1:0]    rd_idx,
    output logic [EW-1:0]    rd_data,
    output logic [LW-1:0]    vlen_o,
    output logic [NELEM-1:0] mask_o
);

    typedef struct packed {
        logic             run;
        vop_e             op;
        logic [RW-1:0]    dst;
        logic [RW-1:0]    s1;
        logic [RW-1:0]    s2;
        logic [LW-1:0]    len;
        logic [LW-1:0]    issue;
        logic [NELEM-1:0] mask;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // issue side
    logic          issue_vld;
    logic [IW-1:0] issue_idx;
    logic [EW-1:0] opa, opb;
    logic [EW-1:0] add_in, mul_in, one_in;
    logic          cmp_bit;

    // unit outputs
    logic          add_vld, mul_vld, one_vld;
    logic [IW-1:0] add_idx, mul_idx, one_idx;
    logic [EW-1:0] add_out, mul_out, one_out;

    // writeback side
    logic          wb_vld;
    logic [IW-1:0] wb_idx;
    logic [EW-1:0] wb_data;
    logic          wb_last;
    logic          rf_we;

    assign issue_vld = ctl_q.run && (ctl_q.issue < ctl_q.len);
    assign issue_idx = ctl_q.issue[IW-1:0];

    vmu_regfile #(.NREG(NREG), .NELEM(NELEM), .EW(EW)) rf_i (
        .clk     (clk),
        .ra_reg  (ctl_q.s1),
        .ra_idx  (issue_idx),
        .ra_data (opa),
        .rb_reg  (ctl_q.s2),
        .rb_idx  (issue_idx),
        .rb_data (opb),
        .rc_reg  (rd_reg),
        .rc_idx  (rd_idx),
        .rc_data (rd_data),
        .ld_en   (ld_en),
        .ld_reg  (ld_reg),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .wb_en   (rf_we),
        .wb_reg  (ctl_q.dst),
        .wb_idx  (wb_idx),
        .wb_data (wb_data)
    );

    assign cmp_bit = (ctl_q.op == OP_CMPEQZ) ? (opa == '0) : (opa != '0);
    assign add_in  = opa + opb;
    assign mul_in  = opa * opb;
    assign one_in  = (ctl_q.op == OP_SHR) ? (opa >> 1) : EW'(cmp_bit);

    vmu_pipe #(.LAT(ADD_LAT), .W(EW), .IW(IW)) add_pipe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (issue_vld && (ctl_q.op == OP_ADD)),
        .in_idx   (issue_idx),
        .in_data  (add_in),
        .out_vld  (add_vld),
        .out_idx  (add_idx),
        .out_data (add_out)
    );

    vmu_pipe #(.LAT(MUL_LAT), .W(EW), .IW(IW)) mul_pipe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (issue_vld && (ctl_q.op == OP_MUL)),
        .in_idx   (issue_idx),
        .in_data  (mul_in),
        .out_vld  (mul_vld),
        .out_idx  (mul_idx),
        .out_data (mul_out)
    );

    vmu_pipe #(.LAT(ONE_LAT), .W(EW), .IW(IW)) one_pipe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (issue_vld && ((ctl_q.op == OP_SHR) || op_cmp(ctl_q.op))),
        .in_idx   (issue_idx),
        .in_data  (one_in),
        .out_vld  (one_vld),
        .out_idx  (one_idx),
        .out_data (one_out)
    );

    always_comb begin
        unique case (ctl_q.op)
            OP_ADD: begin
                wb_vld  = add_vld;
                wb_idx  = add_idx;
                wb_data = add_out;
            end
            OP_MUL: begin
                wb_vld  = mul_vld;
                wb_idx  = mul_idx;
                wb_data = mul_out;
            end
            default: begin
                wb_vld  = one_vld;
                wb_idx  = one_idx;
                wb_data = one_out;
            end
        endcase
    end

    assign wb_last = wb_vld && (LW'(wb_idx) == (ctl_q.len - LW'(1)));
    assign rf_we   = wb_vld && op_arith(ctl_q.op) && ctl_q.mask[wb_idx];

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;

        if (issue_vld) ctl_d.issue = ctl_q.issue + LW'(1);

        if (wb_vld && op_cmp(ctl_q.op)) ctl_d.mask[wb_idx] = wb_data[0];

        if (wb_last) begin
            ctl_d.run  = 1'b0;
            ctl_d.done = 1'b1;
        end

        if (cmd_valid && !ctl_q.run) begin
            unique case (vop_e'(cmd_op))
                OP_SETLEN: begin
                    ctl_d.len  = (cmd_len > LW'(NELEM)) ? LW'(NELEM) : cmd_len;
                    ctl_d.done = 1'b1;
                end
                OP_MASKALL: begin
                    ctl_d.mask = '1;
                    ctl_d.done = 1'b1;
                end
                OP_NOP: begin
                    ctl_d.done = 1'b1;
                end
                default: begin
                    if (ctl_q.len == '0) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.run   = 1'b1;
                        ctl_d.op    = vop_e'(cmd_op);
                        ctl_d.dst   = cmd_dst;
                        ctl_d.s1    = cmd_src1;
                        ctl_d.s2    = cmd_src2;
                        ctl_d.issue = '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.op    <= OP_NOP;
            ctl_q.len   <= LW'(NELEM);
            ctl_q.mask  <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_ready = !ctl_q.run;
    assign busy      = ctl_q.run;
    assign done      = ctl_q.done;
    assign vlen_o    = ctl_q.len;
    assign mask_o    = ctl_q.mask;

endmodule

// File: rtl/vmu_checker.sv
module vmu_checker #(
    parameter int NELEM = 64,
    parameter int LW    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_op,
    input logic [LW-1:0]    cmd_len,
    input logic             busy,
    input logic             done,
    input logic [LW-1:0]    vlen_o,
    input logic [NELEM-1:0] mask_o
);

    p_len_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vlen_o <= LW'(NELEM));

    p_setlen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 3'd5) |=>
        (vlen_o == (($past(cmd_len) > LW'(NELEM)) ? LW'(NELEM) : $past(cmd_len))));

    p_maskall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 3'd6) |=> (mask_o == '1));

    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_busy_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op <= 3'd4 && vlen_o == '0) |=> (done && !busy));

    p_len_hold_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(vlen_o));

endmodule

bind vec_mask_unit vmu_checker #(.NELEM(NELEM), .LW(LW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_len   (cmd_len),
    .busy      (busy),
    .done      (done),
    .vlen_o    (vlen_o),
    .mask_o    (mask_o)
);

// File: tb/vec_mask_unit_tb_top.sv
module vec_mask_unit_tb_top;
    import vmu_pkg::*;

    localparam int NREG  = 4;
    localparam int NELEM = 8;
    localparam int EW    = 8;
    localparam int RW    = $clog2(NREG);
    localparam int IW    = $clog2(NELEM);
    localparam int LW    = $clog2(NELEM + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [2:0]       cmd_op = 3'd7;
    logic [RW-1:0]    cmd_dst = '0, cmd_src1 = '0, cmd_src2 = '0;
    logic [LW-1:0]    cmd_len = '0;
    logic             busy, done;
    logic             ld_en = 1'b0;
    logic [RW-1:0]    ld_reg = '0;
    logic [IW-1:0]    ld_idx = '0;
    logic [EW-1:0]    ld_data = '0;
    logic [RW-1:0]    rd_reg = '0;
    logic [IW-1:0]    rd_idx = '0;
    logic [EW-1:0]    rd_data;
    logic [LW-1:0]    vlen_o;
    logic [NELEM-1:0] mask_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [EW-1:0]    m_rf [NREG][NELEM];
    logic [NELEM-1:0] m_mask;
    int               m_len;

    always #10 clk = ~clk;

    vec_mask_unit #(.NREG(NREG), .NELEM(NELEM), .EW(EW), .ADD_LAT(4), .MUL_LAT(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_src1(cmd_src1), .cmd_src2(cmd_src2),
        .cmd_len(cmd_len), .busy(busy), .done(done), .ld_en(ld_en), .ld_reg(ld_reg),
        .ld_idx(ld_idx), .ld_data(ld_data), .rd_reg(rd_reg), .rd_idx(rd_idx),
        .rd_data(rd_data), .vlen_o(vlen_o), .mask_o(mask_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int r, input int i, input logic [EW-1:0] v);
        ld_en = 1'b1; ld_reg = RW'(r); ld_idx = IW'(i); ld_data = v;
        @(posedge clk); @(negedge clk);
        ld_en = 1'b0;
        m_rf[r][i] = v;
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R2/R11 length"}, vlen_o, m_len);
        chk({tag, " R6/R8 predicate"}, mask_o, m_mask);
        for (int r = 0; r < NREG; r++) begin
            for (int i = 0; i < NELEM; i++) begin
                rd_reg = RW'(r); rd_idx = IW'(i);
                #1;
                chk({tag, " R7/R12 element"}, rd_data, m_rf[r][i]);
            end
        end
    endtask

    function automatic int lat_of(input logic [2:0] op);
        if (op == OP_ADD) return 4;
        if (op == OP_MUL) return 6;
        return 1;
    endfunction

    task automatic run_cmd(input logic [2:0] op, input int d, input int a, input int b,
                           input int len, input string tag);
        int  exp_k;
        int  k;
        bit  busy_ok;
        bit  vec;
        vec   = (op <= 3'd4);
        exp_k = (!vec || m_len == 0) ? 0 : lat_of(op) + m_len - 1;
        cmd_valid = 1'b1; cmd_op = op; cmd_dst = RW'(d); cmd_src1 = RW'(a);
        cmd_src2 = RW'(b); cmd_len = LW'(len);
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        k = 0; busy_ok = 1'b1;
        while (done !== 1'b1 && k < 300) begin
            if (busy !== 1'b1 || cmd_ready !== 1'b0) busy_ok = 1'b0;
            if (exp_k >= 2 && k == 1) begin
                // R11: a length change offered while busy must be dropped
                cmd_valid = 1'b1; cmd_op = OP_SETLEN; cmd_len = LW'(1);
            end else begin
                cmd_valid = 1'b0;
            end
            @(posedge clk); @(negedge clk);
            k++;
        end
        cmd_valid = 1'b0;
        chk((vec && m_len == 0) ? {tag, " R10 zero-length done"} : {tag, " R9 done timing"}, k, exp_k);
        if (exp_k > 0) chk({tag, " R9/R11 busy and not ready while running"}, busy_ok, 1);
        chk({tag, " R9 busy low at done"}, busy, 0);
        // reference update
        for (int i = 0; i < NELEM; i++) begin
            if (i < m_len) begin
                case (op)
                    OP_ADD:    if (m_mask[i]) m_rf[d][i] = m_rf[a][i] + m_rf[b][i];
                    OP_SHR:    if (m_mask[i]) m_rf[d][i] = m_rf[a][i] >> 1;
                    OP_MUL:    if (m_mask[i]) m_rf[d][i] = m_rf[a][i] * m_rf[b][i];
                    OP_CMPEQZ: m_mask[i] = (m_rf[a][i] == 0);
                    OP_CMPNEZ: m_mask[i] = (m_rf[a][i] != 0);
                    default: ;
                endcase
            end
        end
        if (op == OP_SETLEN) m_len = (len > NELEM) ? NELEM : len;
        if (op == OP_MASKALL) m_mask = '1;
        @(posedge clk); @(negedge clk);
        chk({tag, " R9 done is one cycle"}, done, 0);
        compare_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int lens[5] = '{8, 5, 1, 0, 12};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 length", vlen_o, NELEM);
        chk("R1 predicate", mask_o, {NELEM{1'b1}});
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 ready", cmd_ready, 1);
        m_len  = NELEM;
        m_mask = '1;

        for (int rnd = 0; rnd < 5; rnd++) begin
            for (int r = 0; r < NREG; r++) begin
                for (int i = 0; i < NELEM; i++) begin
                    logic [EW-1:0] v;
                    v = EW'(r * 53 + i * 29 + rnd * 17 + 7);
                    if (r == 3) v = (((i + rnd) % 3) == 0) ? '0 : EW'(i + 1 + rnd);
                    load(r, i, v);
                end
            end
            compare_all("R12 load");
            run_cmd(OP_SETLEN,  0, 0, 0, lens[rnd], "R2 setlen");
            run_cmd(OP_CMPNEZ,  0, 3, 0, 0, "R6 nonzero test");
            run_cmd(OP_ADD,     2, 0, 1, 0, "R3 add");
            run_cmd(OP_MUL,     1, 0, 2, 0, "R5 mul");
            run_cmd(OP_SHR,     0, 0, 0, 0, "R4 shift");
            run_cmd(OP_CMPEQZ,  0, 3, 0, 0, "R6 zero test");
            run_cmd(OP_ADD,     3, 3, 1, 0, "R3 add in place");
            run_cmd(OP_MASKALL, 0, 0, 0, 0, "R8 predicate ones");
            run_cmd(OP_MUL,     2, 2, 2, 0, "R5 square");
            run_cmd(OP_SHR,     1, 2, 0, 0, "R4 shift unmasked");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule